// File: doc/BRIEF.md
# Byte-Serial AES-128 Encryption Core

This block encrypts a single 128-bit block under a 128-bit key with a datapath one byte wide. A single byte substitution unit serves both the data state and the key expansion, so each round is a sequence of byte steps rather than one wide operation. The state and the key are mapped into the composite field GF((2^4)^2) when the block is loaded. They stay in that representation for all ten rounds and are mapped back only when the ciphertext register is written.

Round keys are produced one at a time from the previous round key, in place, so no expanded schedule is stored. Row rotation is not a separate stage: it is the order in which state bytes are read into the substitution unit. Column mixing is built up in four byte accumulators as the substituted bytes of a column arrive. A user presents plaintext and key, raises `start` while `ready` is high, and collects `ciphertext` when `done` pulses.

Top module: `aes128_byte_enc`

## Requirements
- R1: `ciphertext` equals the standard AES-128 encryption of `plaintext` under `key`. On all three 128-bit buses byte 0 sits in bits 127:120 and the state is filled column by column, so key 000102..0f with plaintext 00112233..ff gives 69c4e0d86a7b0430d8cdb78070b4c55a.
- R2: While reset is active and after it is released, `ready` is 1, `done` is 0 and `ciphertext` is all zero.
- R3: `start` is sampled on a rising clock edge only when `ready` is 1. From the next cycle `ready` stays 0 until the block finishes.
- R4: `done` is high for exactly one cycle. It rises on the 336th rising edge after the edge that accepted `start`.
- R5: A `start` raised while `ready` is 0 has no effect: it produces no extra `done` pulse, and the running result is unchanged.
- R6: `plaintext` and `key` are captured on the accepting edge. Changes to them while the block is busy do not alter the result.
- R7: `ready` is 1 in the same cycle as `done`. A `start` held high is therefore accepted on the next edge, and two such accepts lie 337 cycles apart.
- R8: `ciphertext` changes only on the edge that raises `done`, and it holds its value until the next `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to encrypt the presented block |
| ready | output | 1 | Block is idle and will accept `start` |
| plaintext | input | 128 | Block to encrypt, byte 0 in bits 127:120 |
| key | input | 128 | Cipher key, byte 0 in bits 127:120 |
| ciphertext | output | 128 | Encrypted block, byte 0 in bits 127:120 |
| done | output | 1 | One-cycle pulse marking a new ciphertext |

## Verification
The hardest situations to reach from the ports are a request arriving while the core is mid-computation and an accept landing in the very cycle a result is delivered. The stimulus pulses `start` with different data part way through a run. It then watches long past the end to confirm that no second result appears. It also holds `start` high across the completion edge to force an immediate second accept, and changes `plaintext` and `key` right after acceptance to show that the captured copy is the one used.

// File: rtl/aes_ser_pkg.sv
package aes_ser_pkg;

  localparam int BLK_BYTES = 16;
  localparam int STEP_W    = $clog2(BLK_BYTES);

  // strobes from the sequencer to the byte datapath
  typedef struct packed {
    logic              load;
    logic              arkEn;
    logic              keyEn;
    logic              subEn;
    logic [STEP_W-1:0] step;
    logic              lastStep;
    logic              lastRound;
    logic              finish;
  } ctrl_t;

  // GF(2^4) product, field polynomial x^4 + x + 1
  function automatic logic [3:0] gf16Mul(input logic [3:0] a, input logic [3:0] b);
    logic [3:0] p;
    logic [3:0] s;
    p = '0;
    s = a;
    for (int i = 0; i < 4; i++) begin
      if (b[i]) p = p ^ s;
      s = {s[2:0], 1'b0} ^ (s[3] ? 4'h3 : 4'h0);
    end
    return p;
  endfunction

  // a^14 is the inverse of a (zero maps to zero)
  function automatic logic [3:0] gf16Inv(input logic [3:0] a);
    logic [3:0] a2, a4, a8;
    a2 = gf16Mul(a, a);
    a4 = gf16Mul(a2, a2);
    a8 = gf16Mul(a4, a4);
    return gf16Mul(gf16Mul(a8, a4), a2);
  endfunction

  // smallest nu making y^2 + y + nu irreducible over GF(2^4)
  function automatic logic [3:0] findNu();
    logic [3:0] nu;
    logic       found;
    logic       hasRoot;
    nu = 4'h0;
    found = 1'b0;
    for (int n = 1; n < 16; n++) begin
      hasRoot = 1'b0;
      for (int g = 0; g < 16; g++)
        if ((gf16Mul(4'(g), 4'(g)) ^ 4'(g) ^ 4'(n)) == 4'h0) hasRoot = 1'b1;
      if (!hasRoot && !found) begin
        nu = 4'(n);
        found = 1'b1;
      end
    end
    return nu;
  endfunction

  localparam logic [3:0] NU = findNu();

  // composite element {hi,lo} = hi*y + lo with y^2 = y + NU
  function automatic logic [7:0] compMul(input logic [7:0] a, input logic [7:0] b);
    logic [3:0] hh;
    hh = gf16Mul(a[7:4], b[7:4]);
    return {hh ^ gf16Mul(a[7:4], b[3:0]) ^ gf16Mul(a[3:0], b[7:4]),
            gf16Mul(hh, NU) ^ gf16Mul(a[3:0], b[3:0])};
  endfunction

  function automatic logic [7:0] compInv(input logic [7:0] a);
    logic [3:0] nrm, nInv;
    nrm  = gf16Mul(gf16Mul(a[7:4], a[7:4]), NU) ^ gf16Mul(a[7:4], a[3:0]) ^
           gf16Mul(a[3:0], a[3:0]);
    nInv = gf16Inv(nrm);
    return {gf16Mul(nInv, a[7:4]), gf16Mul(nInv, a[7:4] ^ a[3:0])};
  endfunction

  // linear map: column i of m is the image of bit i
  function automatic logic [7:0] matApply(input logic [63:0] m, input logic [7:0] a);
    logic [7:0] r;
    r = '0;
    for (int i = 0; i < 8; i++)
      if (a[i]) r = r ^ m[8*i +: 8];
    return r;
  endfunction

  // a composite element that is a root of the AES polynomial 0x11B
  function automatic logic [7:0] findRoot();
    logic [7:0] root, pw, sum;
    logic       found;
    root = 8'h00;
    found = 1'b0;
    for (int c = 1; c < 256; c++) begin
      pw = 8'h01;
      sum = 8'h00;
      for (int i = 0; i < 9; i++) begin
        if (i == 0 || i == 1 || i == 3 || i == 4 || i == 8) sum = sum ^ pw;
        pw = compMul(pw, 8'(c));
      end
      if (sum == 8'h00 && !found) begin
        root = 8'(c);
        found = 1'b1;
      end
    end
    return root;
  endfunction

  function automatic logic [63:0] buildToMat();
    logic [63:0] m;
    logic [7:0]  pw, rt;
    rt = findRoot();
    pw = 8'h01;
    m  = '0;
    for (int i = 0; i < 8; i++) begin
      m[8*i +: 8] = pw;
      pw = compMul(pw, rt);
    end
    return m;
  endfunction

  localparam logic [63:0] TO_COMP = buildToMat();

  function automatic logic [63:0] buildFromMat();
    logic [63:0] m;
    logic [7:0]  img;
    m = '0;
    for (int a = 0; a < 256; a++) begin
      img = matApply(TO_COMP, 8'(a));
      for (int j = 0; j < 8; j++)
        if (img == (8'h01 << j)) m[8*j +: 8] = 8'(a);
    end
    return m;
  endfunction

  localparam logic [63:0] FROM_COMP = buildFromMat();

  // linear part of the substitution affine step, standard basis
  function automatic logic [7:0] affLin(input logic [7:0] a);
    return a ^ {a[6:0], a[7]} ^ {a[5:0], a[7:6]} ^ {a[4:0], a[7:5]} ^ {a[3:0], a[7:4]};
  endfunction

  function automatic logic [63:0] buildAffMat();
    logic [63:0] m;
    m = '0;
    for (int j = 0; j < 8; j++)
      m[8*j +: 8] = matApply(TO_COMP, affLin(matApply(FROM_COMP, 8'h01 << j)));
    return m;
  endfunction

  localparam logic [63:0] AFF_MAT = buildAffMat();
  localparam logic [7:0]  AFF_K   = matApply(TO_COMP, 8'h63);
  localparam logic [7:0]  MIX2    = matApply(TO_COMP, 8'h02);

endpackage

// File: rtl/aes_ser_sbox.sv
module aes_ser_sbox
  import aes_ser_pkg::*;
(
  input  logic [7:0] byteIn,
  output logic [7:0] byteOut
);
  logic [7:0] invByte;

  always_comb begin
    invByte = compInv(byteIn);
    byteOut = matApply(AFF_MAT, invByte) ^ AFF_K;
  end
endmodule

// File: rtl/aes_ser_ctrl.sv
module aes_ser_ctrl
  import aes_ser_pkg::*;
#(
  parameter int ROUNDS = 10
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  start,
  output logic  ready,
  output ctrl_t ctl
);
  localparam int RND_W = $clog2(ROUNDS + 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(BLK_BYTES - 1);

  typedef enum logic [1:0] {PH_IDLE, PH_ARK, PH_KEY, PH_SUB} phase_t;

  phase_t            phase;
  logic [RND_W-1:0]  roundIdx;
  logic [STEP_W-1:0] step;
  logic              atLast;

  assign atLast = (step == LAST_STEP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      roundIdx <= '0;
      step     <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase    <= PH_ARK;
          roundIdx <= RND_W'(1);
          step     <= '0;
        end
        PH_ARK: begin
          step <= step + 1'b1;
          if (atLast) phase <= PH_KEY;
        end
        PH_KEY: begin
          step <= step + 1'b1;
          if (atLast) phase <= PH_SUB;
        end
        default: begin
          step <= step + 1'b1;
          if (atLast) begin
            if (roundIdx == RND_W'(ROUNDS)) phase <= PH_IDLE;
            else begin
              roundIdx <= roundIdx + 1'b1;
              phase    <= PH_KEY;
            end
          end
        end
      endcase
    end
  end

  always_comb begin
    ready         = (phase == PH_IDLE);
    ctl.load      = ready && start;
    ctl.arkEn     = (phase == PH_ARK);
    ctl.keyEn     = (phase == PH_KEY);
    ctl.subEn     = (phase == PH_SUB);
    ctl.step      = step;
    ctl.lastStep  = atLast;
    ctl.lastRound = (roundIdx == RND_W'(ROUNDS));
    ctl.finish    = ctl.subEn && atLast && ctl.lastRound;
  end
endmodule

// File: rtl/aes_ser_dp.sv
module aes_ser_dp
  import aes_ser_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  ctrl_t        ctl,
  input  logic [127:0] ptext,
  input  logic [127:0] keyIn,
  output logic [127:0] ctext,
  output logic         done
);
  logic [7:0] cur    [BLK_BYTES];
  logic [7:0] nxt    [BLK_BYTES];
  logic [7:0] rk     [BLK_BYTES];
  logic [7:0] merged [BLK_BYTES];
  logic [7:0] acc    [4];
  logic [7:0] accNew [4];
  logic [7:0] colOut [4];
  logic [7:0] rcon;

  logic [1:0] row, colSel, srcCol;
  logic [3:0] srcIdx, keyTapIdx;
  logic [7:0] sboxIn, sboxOut, keyNew, mul2, mul3;

  assign row       = ctl.step[1:0];
  assign colSel    = ctl.step[3:2];
  assign srcCol    = colSel + row;
  assign srcIdx    = {srcCol, row};
  assign keyTapIdx = {2'd3, row + 2'd1};

  assign sboxIn = ctl.keyEn ? rk[keyTapIdx] : cur[srcIdx];

  aes_ser_sbox sbox_i (.byteIn(sboxIn), .byteOut(sboxOut));

  always_comb begin
    if (colSel == 2'd0)
      keyNew = rk[ctl.step] ^ sboxOut ^ ((row == 2'd0) ? rcon : 8'h00);
    else
      keyNew = rk[ctl.step] ^ rk[ctl.step - 4'd4];
  end

  always_comb begin
    logic [7:0] contrib;
    mul2 = compMul(sboxOut, MIX2);
    mul3 = mul2 ^ sboxOut;
    for (int r = 0; r < 4; r++) begin
      if (ctl.lastRound)            contrib = (2'(r) == row) ? sboxOut : 8'h00;
      else if (2'(r) == row)        contrib = mul2;
      else if (2'(r) == row - 2'd1) contrib = mul3;
      else                          contrib = sboxOut;
      accNew[r] = ((row == 2'd0) ? 8'h00 : acc[r]) ^ contrib;
      colOut[r] = accNew[r] ^ rk[{colSel, 2'(r)}];
    end
    for (int i = 0; i < BLK_BYTES; i++)
      merged[i] = (i >= BLK_BYTES - 4) ? colOut[i - (BLK_BYTES - 4)] : nxt[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < BLK_BYTES; i++) begin
        cur[i] <= '0;
        nxt[i] <= '0;
        rk[i]  <= '0;
      end
      for (int r = 0; r < 4; r++) acc[r] <= '0;
      rcon  <= '0;
      ctext <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (ctl.load) begin
        for (int i = 0; i < BLK_BYTES; i++) begin
          cur[i] <= matApply(TO_COMP, ptext[127 - 8*i -: 8]);
          rk[i]  <= matApply(TO_COMP, keyIn[127 - 8*i -: 8]);
        end
        rcon <= 8'h01;
      end
      if (ctl.arkEn) cur[ctl.step] <= cur[ctl.step] ^ rk[ctl.step];
      if (ctl.keyEn) begin
        rk[ctl.step] <= keyNew;
        if (ctl.lastStep) rcon <= compMul(rcon, MIX2);
      end
      if (ctl.subEn) begin
        for (int r = 0; r < 4; r++) acc[r] <= accNew[r];
        if (row == 2'd3)
          for (int r = 0; r < 4; r++) nxt[{colSel, 2'(r)}] <= colOut[r];
        if (ctl.lastStep)
          for (int i = 0; i < BLK_BYTES; i++) cur[i] <= merged[i];
        if (ctl.finish) begin
          done <= 1'b1;
          for (int i = 0; i < BLK_BYTES; i++)
            ctext[127 - 8*i -: 8] <= matApply(FROM_COMP, merged[i]);
        end
      end
    end
  end
endmodule

// File: rtl/aes128_byte_enc.sv
module aes128_byte_enc
  import aes_ser_pkg::*;
#(
  parameter int ROUNDS = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  output logic         ready,
  input  logic [127:0] plaintext,
  input  logic [127:0] key,
  output logic [127:0] ciphertext,
  output logic         done
);
  ctrl_t ctl;

  aes_ser_ctrl #(.ROUNDS(ROUNDS)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .ready(ready), .ctl(ctl)
  );

  aes_ser_dp dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .ptext(plaintext), .keyIn(key),
    .ctext(ciphertext), .done(done)
  );
endmodule

// File: rtl/aes128_byte_enc_chk.sv
module aes128_byte_enc_chk #(
  parameter int ROUNDS = 10
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic         ready,
  input logic [127:0] ciphertext,
  input logic         done
);
  localparam int LAT = 16 + ROUNDS * 32;

  logic [15:0] sinceAcc;
  logic        tracking;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceAcc <= '0;
      tracking <= 1'b0;
    end else if (start && ready) begin
      sinceAcc <= '0;
      tracking <= 1'b1;
    end else if (tracking) begin
      sinceAcc <= sinceAcc + 1'b1;
      if (done) tracking <= 1'b0;
    end
  end

  // R3
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && ready) |=> !ready);

  // R4
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R4
  done_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (tracking && sinceAcc == 16'(LAT)));

  // R7
  ready_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ready);

  // R8
  ctext_changes_on_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ciphertext) |-> done);
endmodule

bind aes128_byte_enc aes128_byte_enc_chk #(.ROUNDS(ROUNDS)) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .ready(ready),
  .ciphertext(ciphertext), .done(done)
);

// File: tb/aes128_byte_enc_tb_top.sv
`timescale 1ns/1ps
module aes128_byte_enc_tb_top;
  localparam int LAT = 336;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [127:0] plaintext = '0;
  logic [127:0] key = '0;
  logic         ready, done;
  logic [127:0] ciphertext;

  aes128_byte_enc dut_i (
    .clk(clk), .rstN(rstN), .start(start), .ready(ready),
    .plaintext(plaintext), .key(key), .ciphertext(ciphertext), .done(done)
  );

  always #2.5 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int doneSeen = 0;
  int sent = 0;
  logic [127:0] expQ[$];
  int           accQ[$];
  logic [7:0]   sbT [256];
  logic         prevDone = 1'b0;
  logic         heldBad = 1'b0;
  logic [127:0] lastCt = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, s;
    p = '0;
    s = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ s;
      s = {s[6:0], 1'b0} ^ (s[7] ? 8'h1b : 8'h00);
    end
    return p;
  endfunction

  function automatic logic [127:0] refEnc(input logic [127:0] pt, input logic [127:0] k);
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [7:0] w [16];
    logic [7:0] tw [4];
    logic [7:0] rc;
    logic [127:0] o;
    rc = 8'h01;
    for (int i = 0; i < 16; i++) begin
      w[i] = k[127 - 8*i -: 8];
      s[i] = pt[127 - 8*i -: 8] ^ w[i];
    end
    for (int rnd = 1; rnd <= 10; rnd++) begin
      for (int i = 0; i < 16; i++)
        t[i] = sbT[s[(i % 4) + 4 * (((i / 4) + (i % 4)) % 4)]];
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++)
          if (rnd < 10)
            s[4*c + r] = gm(t[4*c + r], 8'h02) ^ gm(t[4*c + (r+1)%4], 8'h03) ^
                         t[4*c + (r+2)%4] ^ t[4*c + (r+3)%4];
          else
            s[4*c + r] = t[4*c + r];
      tw[0] = sbT[w[13]] ^ rc;
      tw[1] = sbT[w[14]];
      tw[2] = sbT[w[15]];
      tw[3] = sbT[w[12]];
      for (int i = 0; i < 4; i++) w[i] = w[i] ^ tw[i];
      for (int i = 4; i < 16; i++) w[i] = w[i] ^ w[i-4];
      rc = gm(rc, 8'h02);
      for (int i = 0; i < 16; i++) s[i] = s[i] ^ w[i];
    end
    for (int i = 0; i < 16; i++) o[127 - 8*i -: 8] = s[i];
    return o;
  endfunction

  // monitor: pops the scoreboard on every result
  always @(negedge clk) begin
    if (rstN) begin
      if (done) begin
        doneSeen++;
        check(!prevDone, "R4 done lasts one cycle", 128'(prevDone), 128'(0));
        check(!heldBad, "R8 ciphertext held between results", 128'(heldBad), 128'(0));
        check(ready, "R7 ready high with done", 128'(ready), 128'(1));
        if (expQ.size() == 0) begin
          check(1'b0, "R5 unexpected result", ciphertext, 128'(0));
        end else begin
          logic [127:0] e;
          int a;
          e = expQ.pop_front();
          a = accQ.pop_front();
          check(ciphertext == e, "R1 ciphertext", ciphertext, e);
          check(cyc - a == LAT, "R4 latency", 128'(cyc - a), 128'(LAT));
        end
        lastCt  = ciphertext;
        heldBad = 1'b0;
      end else if (ciphertext != lastCt) begin
        heldBad = 1'b1;
      end
      prevDone = done;
    end
  end

  // driver: request one block and push its expected result
  task automatic send(input logic [127:0] pt, input logic [127:0] k, input bit hold);
    @(negedge clk);
    while (!ready) @(negedge clk);
    plaintext = pt;
    key = k;
    start = 1'b1;
    @(negedge clk);
    accQ.push_back(cyc);
    expQ.push_back(refEnc(pt, k));
    sent++;
    check(!ready, "R3 ready drops after accept", 128'(ready), 128'(0));
    if (!hold) start = 1'b0;
  endtask

  task automatic waitIdle();
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", sent, doneSeen);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int accA;
    for (int a = 0; a < 256; a++) begin
      logic [7:0] inv, x;
      inv = 8'h00;
      for (int b = 1; b < 256; b++) if (gm(8'(a), 8'(b)) == 8'h01) inv = 8'(b);
      x = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^ {inv[4:0], inv[7:5]} ^
          {inv[3:0], inv[7:4]} ^ 8'h63;
      sbT[a] = x;
    end

    repeat (4) @(negedge clk);
    // R2 values during reset and right after release
    check(ready == 1'b1, "R2 ready in reset", 128'(ready), 128'(1));
    check(done == 1'b0, "R2 done in reset", 128'(done), 128'(0));
    rstN = 1'b1;
    @(negedge clk);
    check(ciphertext == '0, "R2 ciphertext after reset", ciphertext, '0);
    check(ready == 1'b1 && done == 1'b0, "R2 idle after reset", {ready, done}, 128'(2));

    // R1 standard vectors
    send(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f, 1'b0);
    waitIdle();
    check(ciphertext == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R1 vector one",
          ciphertext, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    send(128'h3243f6a8885a308d313198a2e0370734, 128'h2b7e151628aed2a6abf7158809cf4f3c, 1'b0);
    waitIdle();
    check(ciphertext == 128'h3925841d02dc09fbdc118597196a0b32, "R1 vector two",
          ciphertext, 128'h3925841d02dc09fbdc118597196a0b32);
    send('0, '0, 1'b0);
    waitIdle();
    check(ciphertext == 128'h66e94bd4ef8a2c3b884cfa59ca342b2e, "R1 all zero",
          ciphertext, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e);
    send('1, '1, 1'b0);
    waitIdle();

    // R6 inputs changed right after accept; R5 start pulsed while busy
    send(128'hdeadbeef_01234567_89abcdef_fedcba98, 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0, 1'b0);
    plaintext = ~plaintext;
    key = {key[63:0], key[127:64]};
    repeat (40) @(negedge clk);
    plaintext = 128'h5555;
    start = 1'b1;
    repeat (3) @(negedge clk);
    check(!ready, "R5 ready stays low under busy start", 128'(ready), 128'(0));
    start = 1'b0;
    waitIdle();
    repeat (400) @(negedge clk);
    check(doneSeen == sent, "R5 no extra result", 128'(doneSeen), 128'(sent));

    // R7 start held high across completion
    send(128'h0123, 128'h4567, 1'b1);
    accA = accQ[0];
    send(128'h89ab, 128'hcdef, 1'b1);
    check(accQ[0] - accA == LAT + 1, "R7 back to back spacing", 128'(accQ[0] - accA),
          128'(LAT + 1));
    start = 1'b0;
    waitIdle();

    for (int n = 0; n < 4; n++)
      send({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom}, 1'b0);
    waitIdle();
    repeat (20) @(negedge clk);
    check(doneSeen == sent, "R4 one result per request", 128'(doneSeen), 128'(sent));
    check(ready && !done, "R3 idle at end", {ready, done}, 128'(2));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule